// File: doc/BRIEF.md
# Bus Hold Handover Controller

This block decides when the local processor gives its system bus away to an external master and when it takes the bus back. The external master raises a hold request. The controller passes this request through a synchronizer and compares it with the phase indicators from the local bus sequencer. It issues the grant only at a point where no local transfer is in progress. When it grants, it raises the acknowledge, tells the sequencer to float every address, data and control driver, and keeps the sequencer from starting new local cycles.

The phase inputs mark the sequencer's T1 (address) state, its T4 (closing) state, and a bus-idle state. When none of the three is active, the sequencer is in the middle of a transfer (T2, T3 or a wait state). A grant is allowed only in an idle, T1 or T4 clock. A T1 that coincides with a grant is withdrawn by the sequencer, because it sees the stall, and that T1 is issued again after the bus comes back. While the acknowledge is high, every later bus cycle belongs to the external master. When the request drops, the acknowledge falls, the drivers stay floated for one more clock, and then the processor owns the bus again.

Top module: `hold_handover`

## Requirements
- R1: While reset is high, and in the first clock after it, the acknowledge, float and stall outputs are all 0.
- R2: The hold request passes through two synchronizer flops. A change on the request pin can affect the grant decision no earlier than the clock after the second flop has captured it. With the bus idle, the acknowledge rises on the third rising edge after the pin rises.
- R3: If the synchronized request is high in a clock where the processor owns the bus and one of idle, T1 or T4 is active, the acknowledge is high from the next rising edge.
- R4: If the synchronized request is high in a clock where none of idle, T1 or T4 is active, no grant is made at the next edge. The grant waits for an idle, T1 or T4 clock.
- R5: While the acknowledge is high and the synchronized request stays high, the acknowledge stays high whatever the phase inputs do.
- R6: A synchronized request that is low while the acknowledge is high makes the acknowledge fall at the next rising edge.
- R7: The float output rises on the same edge as the acknowledge. It stays high in the clock after the acknowledge falls, and falls only after that clock.
- R8: The stall output is high in any clock where a grant is being decided (synchronized request high, bus owned locally, idle, T1 or T4 active). It is also high whenever the acknowledge or the float output is high, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_req | input | 1 | Bus request from the external master, asynchronous |
| phase_t1 | input | 1 | Sequencer is in its address state T1 |
| phase_t4 | input | 1 | Sequencer is in its closing state T4 |
| phase_idle | input | 1 | Sequencer has no bus cycle running |
| hlda | output | 1 | Hold acknowledge to the external master |
| bus_float | output | 1 | Float all bus drivers (tristate enable) |
| local_stall | output | 1 | Block the sequencer from starting a new T1 |

## Verification
The request is raised in idle, T1 and T4 clocks, where an immediate grant separates a correct boundary decode from one that ignores a phase. It is also raised during runs of mid-cycle clocks, where a premature grant would cut a local transfer short. Exact latency counts from the pin edge expose a missing or extra synchronizer stage, and release sequences show whether the acknowledge and the float output fall on separate edges. A long random stretch, with phases and request toggles that often collide, is compared cycle by cycle against a reference model. This catches interactions the directed cases miss, such as a request that falls again during the release clock.

// File: rtl/hho_pkg.sv
package hho_pkg;

    typedef enum logic [1:0] {
        HH_OWN    = 2'd0,
        HH_GRANT  = 2'd1,
        HH_RETURN = 2'd2
    } hh_state_e;

    typedef struct packed {
        logic t1;
        logic t4;
        logic idle;
    } hh_phase_s;

    typedef struct packed {
        logic ack;
        logic float_en;
        logic stall;
    } hh_out_s;

    function automatic logic hh_at_boundary(hh_phase_s p, logic allow_t1);
        return p.idle | p.t4 | (allow_t1 & p.t1);
    endfunction

endpackage

// File: rtl/hho_sync.sv
module hho_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/hho_window.sv
module hho_window
    import hho_pkg::*;
#(
    parameter bit T1_GRANT = 1'b1
) (
    input  hh_phase_s phase,
    output logic      boundary
);
    generate
        if (T1_GRANT) begin : g_with_t1
            assign boundary = hh_at_boundary(phase, 1'b1);
        end else begin : g_no_t1
            assign boundary = hh_at_boundary(phase, 1'b0);
        end
    endgenerate
endmodule

// File: rtl/hho_fsm.sv
module hho_fsm
    import hho_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      hold_s,
    input  logic      boundary,
    output hh_state_e state,
    output hh_out_s   outs
);
    hh_state_e nxt;
    logic      decide;

    assign decide = (state == HH_OWN) && hold_s && boundary;

    always_comb begin
        nxt = state;
        case (state)
            HH_OWN:    if (decide) nxt = HH_GRANT;
            HH_GRANT:  if (!hold_s) nxt = HH_RETURN;
            HH_RETURN: nxt = HH_OWN;
            default:   nxt = HH_OWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= HH_OWN;
        else     state <= nxt;
    end

    always_comb begin
        outs.ack      = (state == HH_GRANT);
        outs.float_en = (state != HH_OWN);
        outs.stall    = (state != HH_OWN) || decide;
    end
endmodule

// File: rtl/hold_handover.sv
module hold_handover
    import hho_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter bit T1_GRANT    = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_req,
    input  logic phase_t1,
    input  logic phase_t4,
    input  logic phase_idle,
    output logic hlda,
    output logic bus_float,
    output logic local_stall
);
    logic      hold_sync;
    logic      boundary;
    hh_phase_s phase;
    hh_state_e state;
    hh_out_s   outs;

    assign phase = '{t1: phase_t1, t4: phase_t4, idle: phase_idle};

    hho_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .din (hold_req),
        .dout(hold_sync)
    );

    hho_window #(.T1_GRANT(T1_GRANT)) u_win (
        .phase   (phase),
        .boundary(boundary)
    );

    hho_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .hold_s  (hold_sync),
        .boundary(boundary),
        .state   (state),
        .outs    (outs)
    );

    assign hlda        = outs.ack;
    assign bus_float   = outs.float_en;
    assign local_stall = outs.stall;
endmodule

// File: rtl/hho_checker.sv
module hho_checker (
    input logic clk,
    input logic rst,
    input logic hold_sync,
    input logic phase_t1,
    input logic phase_t4,
    input logic phase_idle,
    input logic hlda,
    input logic bus_float,
    input logic local_stall
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!hlda && !bus_float));

    assert_grant_at_boundary_R3: assert property (@(posedge clk) disable iff (rst)
        (hold_sync && !bus_float && (phase_t1 || phase_t4 || phase_idle)) |=> hlda);

    assert_defer_mid_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (!hlda && !phase_t1 && !phase_t4 && !phase_idle) |=> !hlda);

    assert_keep_while_held_R5: assert property (@(posedge clk) disable iff (rst)
        (hlda && hold_sync) |=> hlda);

    assert_drop_after_release_R6: assert property (@(posedge clk) disable iff (rst)
        (hlda && !hold_sync) |=> !hlda);

    assert_float_with_ack_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(hlda) |-> bus_float);

    assert_float_outlasts_ack_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(hlda) |-> bus_float);

    assert_float_late_fall_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(bus_float) |-> !$past(hlda));

    assert_stall_covers_R8: assert property (@(posedge clk) disable iff (rst)
        (hlda || bus_float) |-> local_stall);
endmodule

bind hold_handover hho_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .hold_sync  (hold_sync),
    .phase_t1   (phase_t1),
    .phase_t4   (phase_t4),
    .phase_idle (phase_idle),
    .hlda       (hlda),
    .bus_float  (bus_float),
    .local_stall(local_stall)
);

// File: tb/sim_hold_handover.sv
`timescale 1ns/1ps
module sim_hold_handover;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_req = 1'b0, phase_t1 = 1'b0, phase_t4 = 1'b0, phase_idle = 1'b0;
    logic hlda, bus_float, local_stall;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    hold_handover u0 (
        .clk(clk), .rst(rst), .hold_req(hold_req),
        .phase_t1(phase_t1), .phase_t4(phase_t4), .phase_idle(phase_idle),
        .hlda(hlda), .bus_float(bus_float), .local_stall(local_stall)
    );

    // reference model: 0 own, 1 granted, 2 returning
    logic [1:0] m_sync;
    int         m_st;
    string      m_tag;

    function automatic logic m_bound(logic t1, logic t4, logic idl);
        return t1 | t4 | idl;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sync <= 2'b00;
            m_st   <= 0;
            m_tag  <= "R1";
        end else begin
            m_sync <= {m_sync[0], hold_req};
            case (m_st)
                0: if (m_sync[1] && m_bound(phase_t1, phase_t4, phase_idle)) begin
                       m_st <= 1; m_tag <= "R3";
                   end else if (m_sync[1]) m_tag <= "R4";
                   else m_tag <= "R2";
                1: if (!m_sync[1]) begin m_st <= 2; m_tag <= "R6"; end
                   else m_tag <= "R5";
                default: begin m_st <= 0; m_tag <= "R6"; end
            endcase
        end
    end

    function automatic logic exp_stall();
        return (m_st != 0) || (m_sync[1] && m_bound(phase_t1, phase_t4, phase_idle));
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_model();
        check(m_tag, hlda, (m_st == 1), "hlda");
        check("R7", bus_float, (m_st != 0), "bus_float");
        check("R8", local_stall, exp_stall(), "local_stall");
    endtask

    task automatic step(input logic h, input logic t1, input logic t4, input logic idl);
        hold_req = h; phase_t1 = t1; phase_t4 = t4; phase_idle = idl;
        @(negedge clk);
        compare_model();
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1", hlda, 1'b0, "hlda in reset");
        check("R1", bus_float, 1'b0, "float in reset");
        check("R1", local_stall, 1'b0, "stall in reset");
        rst = 1'b0;

        // R2, R3: idle grant latency of three edges
        step(1, 0, 0, 1); check("R2", hlda, 1'b0, "edge1");
        step(1, 0, 0, 1); check("R2", hlda, 1'b0, "edge2");
        step(1, 0, 0, 1); check("R3", hlda, 1'b1, "edge3");
        check("R7", bus_float, 1'b1, "float with grant");
        // R5: held through mid-cycle phases
        repeat (3) begin step(1, 0, 0, 0); check("R5", hlda, 1'b1, "held"); end
        // R6, R7: release timing
        step(0, 0, 0, 0); check("R6", hlda, 1'b1, "rel edge1");
        step(0, 0, 0, 0); check("R6", hlda, 1'b1, "rel edge2");
        step(0, 0, 0, 0); check("R6", hlda, 1'b0, "rel edge3");
        check("R7", bus_float, 1'b1, "float after ack fall");
        check("R8", local_stall, 1'b1, "stall during return");
        step(0, 0, 0, 0); check("R7", bus_float, 1'b0, "float released");
        check("R8", local_stall, 1'b0, "stall released");

        // R4: deferred through mid-cycle clocks
        repeat (5) begin
            step(1, 0, 0, 0);
            check("R4", hlda, 1'b0, "no grant mid cycle");
            check("R8", local_stall, 1'b0, "no stall mid cycle");
        end
        hold_req = 1; phase_t4 = 1;
        #1 check("R8", local_stall, 1'b1, "stall in decision clock");
        @(negedge clk); compare_model();
        check("R3", hlda, 1'b1, "grant after T4");
        repeat (4) step(0, 0, 0, 0);
        check("R6", hlda, 1'b0, "released");

        // R3: grant from a T1 clock
        step(1, 0, 0, 0); step(1, 0, 0, 0);
        step(1, 1, 0, 0); check("R3", hlda, 1'b1, "grant from T1");
        repeat (4) step(0, 0, 0, 0);

        // random stretch
        for (int i = 0; i < 3000; i++) begin
            int r;
            logic h;
            r = $urandom_range(0, 9);
            h = ($urandom_range(0, 7) == 0) ? ~hold_req : hold_req;
            step(h, r == 1 || r == 2, r == 3 || r == 4, r == 5 || r == 6);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule